// File: doc/BRIEF.md
# Level-priority interrupt arbiter

This block sits between a set of interrupt lines and a processor core. It captures each raw line into a pending bit, either by following the line (level capture) or by latching an active edge (edge capture). Each source also has an enable bit, an 8-bit control byte, a hardware-vector flag and two trigger-mode bits. Every cycle the arbiter looks at all sources that are both pending and enabled, picks a single winner, and presents the winner's index, its decoded level and its vector flag. It raises a request to the core when that level is strictly above a programmable threshold.

How the control byte splits into a level field and a priority field is set at run time by a level-bit count. Only the top `CTL_BITS` bits of each control byte exist in hardware, and the missing low bits read as ones. The decoded level is the top level bits followed by ones, so with no level bits every interrupt sits at level 255. The result goes through a three-state output machine with the states ARB_IDLE (no source qualifies), ARB_MASKED (a winner exists but its level does not exceed the threshold) and ARB_REQ (a winner exists above the threshold). The machine is re-evaluated every cycle, and any state can move to any other state in one cycle: to ARB_IDLE when no source qualifies, to ARB_MASKED when the winner is at or below the threshold, and to ARB_REQ when the winner is above it.

Top module: `lpa_arbiter`

## Requirements
- R1: While reset is asserted, all pending bits, `irq_o`, `win_id_o`, `win_lvl_o` and `win_vec_o` are zero.
- R2: Only the top `CTL_BITS` bits of each control byte are used. The remaining low bits behave as ones, so changing them never changes the decoded level.
- R3: The effective level-bit count is `min(nlbits_i, CTL_BITS)`. The level is the top that-many bits of the effective byte followed by ones. A count of 0 gives level 255; a count of 1 gives 127 or 255; a count of 2 gives 63, 127, 191 or 255.
- R4: Only sources that are both pending and enabled compete. When none does, `win_id_o` is 0, `win_lvl_o` is 0, `win_vec_o` is 0 and `irq_o` is low (state ARB_IDLE).
- R5: The winner has the highest level. Among equal levels it has the highest priority, where priority is the implemented bits below the level field. Full ties go to the highest source index.
- R6: `irq_o` is high exactly when a winner exists and its level is strictly greater than `thresh_i`.
- R7: With `trig_edge_i[i]`=1, an active edge of the line sets the pending bit. The bit then holds until a `clr_i[i]` pulse, and a line that stays active does not set it again. If a set and a clear arrive in the same cycle, the set wins.
- R8: With `trig_inv_i[i]`=1 the line is inverted. Level capture becomes active-low and edge capture reacts to falling edges.
- R9: With `trig_edge_i[i]`=0 the pending bit equals the active value of the line one cycle later, and `clr_i[i]` has no effect.
- R10: A `sw_set_i[i]` pulse sets pending one cycle later in either mode. In level mode, with the line inactive, the bit stays set for that one cycle only.
- R11: Outputs are registered. A change to enable, control, vector, level count or threshold shows one cycle later; a change on a line shows two cycles later.
- R12: `win_vec_o` equals the winner's `vec_i` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N | Raw interrupt lines |
| trig_edge_i | input | N | Per source: 1 = edge capture, 0 = level capture |
| trig_inv_i | input | N | Per source: 1 = active-low / falling edge |
| sw_set_i | input | N | Per source software set-pending pulse |
| clr_i | input | N | Per source clear-pending pulse (edge mode) |
| ie_i | input | N | Per source enable |
| ctl_i | input | 8*N | Control bytes, source i at bits [8i+7:8i] |
| vec_i | input | N | Per source hardware-vector flag |
| nlbits_i | input | 4 | Requested number of level bits |
| thresh_i | input | 8 | Level threshold |
| pend_o | output | N | Pending bits |
| irq_o | output | 1 | Request to the core |
| win_id_o | output | log2(N) | Winning source index |
| win_lvl_o | output | 8 | Winning decoded level |
| win_vec_o | output | 1 | Winner's vector flag |

## Verification
The bench sweeps every control byte under every level-bit count from 0 to 8. This catches a design that zero-extends the level instead of padding it with ones, or one that fails to clamp a count above `CTL_BITS`. A threshold sweep catches an off-by-one that compares with greater-or-equal. Several hundred arbitrations over random enables, levels and priorities expose tie-breaking toward the lower index or ranking by priority before level. Edge-capture sequences check that the bit holds after the line drops, that a held line does not set it again, that a set beats a simultaneous clear, and that inversion flips the active edge. Level capture and software set are checked to release pending when they should.

// File: rtl/lpa_pkg.sv
package lpa_pkg;

    // Output state of the arbiter.
    typedef enum logic [1:0] {
        ARB_IDLE   = 2'd0,
        ARB_MASKED = 2'd1,
        ARB_REQ    = 2'd2
    } arb_state_e;

    localparam int CTL_W = 8;   // control byte width
    localparam int NLB_W = 4;   // width of the level-bit count input

endpackage

// File: rtl/lpa_capture.sv
module lpa_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] edge_i,
    input  logic [N-1:0] inv_i,
    input  logic [N-1:0] sw_set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] act;
    assign act = src_i ^ inv_i;

    for (genvar i = 0; i < N; i++) begin : g_src
        logic act_q;
        logic p_q;
        logic hit;

        assign hit = (act[i] & ~act_q) | sw_set_i[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                act_q <= 1'b0;
                p_q   <= 1'b0;
            end else begin
                act_q <= act[i];
                if (edge_i[i]) begin
                    if (hit)           p_q <= 1'b1;   // set beats clear
                    else if (clr_i[i]) p_q <= 1'b0;
                end else begin
                    p_q <= act[i] | sw_set_i[i];
                end
            end
        end

        assign pend_o[i] = p_q;

        // Edge-captured pending holds without a clear.
        assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_i[i] && p_q && !clr_i[i]) |=> p_q);

        // Level-captured pending tracks the active line value.
        assert_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!edge_i[i]) |=> (p_q == ($past(act[i]) | $past(sw_set_i[i]))));
    end

endmodule

// File: rtl/lpa_decode.sv
module lpa_decode #(
    parameter int CTL_BITS = 4
) (
    input  logic [7:0] ctl_i,
    input  logic [3:0] nl_i,     // already clamped to CTL_BITS
    output logic [7:0] key_o,    // effective byte: level, priority, ones
    output logic [7:0] lvl_o
);

    localparam logic [7:0] IMPL_MASK = ~(8'hFF >> CTL_BITS);

    assign key_o = (ctl_i & IMPL_MASK) | ~IMPL_MASK;
    assign lvl_o = key_o | (8'hFF >> nl_i);

endmodule

// File: rtl/lpa_select.sv
module lpa_select #(
    parameter int N   = 8,
    parameter int IDW = 3
) (
    input  logic [N*8-1:0] key_i,
    input  logic [N-1:0]   qual_i,
    output logic           found_o,
    output logic [IDW-1:0] win_o
);

    logic [7:0] best;

    // Ascending scan with >= so a full tie goes to the higher index.
    always_comb begin
        found_o = 1'b0;
        best    = '0;
        win_o   = '0;
        for (int i = 0; i < N; i++) begin
            if (qual_i[i] && (!found_o || key_i[i*8 +: 8] >= best)) begin
                found_o = 1'b1;
                best    = key_i[i*8 +: 8];
                win_o   = IDW'(i);
            end
        end
    end

endmodule

// File: rtl/lpa_arbiter.sv
module lpa_arbiter
    import lpa_pkg::*;
#(
    parameter int N        = 8,
    parameter int CTL_BITS = 4,
    localparam int IDW     = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     src_i,
    input  logic [N-1:0]     trig_edge_i,
    input  logic [N-1:0]     trig_inv_i,
    input  logic [N-1:0]     sw_set_i,
    input  logic [N-1:0]     clr_i,
    input  logic [N-1:0]     ie_i,
    input  logic [N*8-1:0]   ctl_i,
    input  logic [N-1:0]     vec_i,
    input  logic [3:0]       nlbits_i,
    input  logic [7:0]       thresh_i,
    output logic [N-1:0]     pend_o,
    output logic             irq_o,
    output logic [IDW-1:0]   win_id_o,
    output logic [7:0]       win_lvl_o,
    output logic             win_vec_o
);

    localparam logic [3:0] CTL_LIM   = 4'(CTL_BITS);
    localparam logic [7:0] LOW_MASK  = 8'hFF >> CTL_BITS;

    logic [N-1:0]   pend;
    logic [N-1:0]   qual;
    logic [3:0]     nl_eff;
    logic [N*8-1:0] key_flat;
    logic [7:0]     lvl_a [N];
    logic           found_c;
    logic [IDW-1:0] win_c;

    arb_state_e state_q, state_d;
    logic [IDW-1:0] id_q;
    logic [7:0]     lvl_q;
    logic           vec_q;

    lpa_capture #(.N(N)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .edge_i   (trig_edge_i),
        .inv_i    (trig_inv_i),
        .sw_set_i (sw_set_i),
        .clr_i    (clr_i),
        .pend_o   (pend)
    );

    assign qual   = pend & ie_i;
    assign nl_eff = (nlbits_i > CTL_LIM) ? CTL_LIM : nlbits_i;

    for (genvar i = 0; i < N; i++) begin : g_dec
        logic [7:0] key_w;
        lpa_decode #(.CTL_BITS(CTL_BITS)) u_dec (
            .ctl_i (ctl_i[i*8 +: 8]),
            .nl_i  (nl_eff),
            .key_o (key_w),
            .lvl_o (lvl_a[i])
        );
        assign key_flat[i*8 +: 8] = key_w;
    end

    lpa_select #(.N(N), .IDW(IDW)) u_sel (
        .key_i   (key_flat),
        .qual_i  (qual),
        .found_o (found_c),
        .win_o   (win_c)
    );

    // Next-state decision.
    always_comb begin
        if (!found_c)                    state_d = ARB_IDLE;
        else if (lvl_a[win_c] > thresh_i) state_d = ARB_REQ;
        else                             state_d = ARB_MASKED;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q  <= '0;
            lvl_q <= '0;
            vec_q <= 1'b0;
        end else begin
            unique case (state_d)
                ARB_IDLE: begin
                    id_q  <= '0;
                    lvl_q <= '0;
                    vec_q <= 1'b0;
                end
                ARB_MASKED, ARB_REQ: begin
                    id_q  <= win_c;
                    lvl_q <= lvl_a[win_c];
                    vec_q <= vec_i[win_c];
                end
                default: begin
                    id_q  <= '0;
                    lvl_q <= '0;
                    vec_q <= 1'b0;
                end
            endcase
        end
    end

    assign pend_o    = pend;
    assign irq_o     = (state_q == ARB_REQ);
    assign win_id_o  = id_q;
    assign win_lvl_o = lvl_q;
    assign win_vec_o = vec_q;

    assert_irq_thr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (win_lvl_o > $past(thresh_i)));

    assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (qual == '0) |=> (!irq_o && win_lvl_o == 8'd0 && win_id_o == '0 && !win_vec_o));

    assert_qual_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_lvl_o != 8'd0) |-> ((($past(qual) >> win_id_o) & N'(1)) != '0));

    assert_pad_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_lvl_o != 8'd0) |-> ((win_lvl_o & LOW_MASK) == LOW_MASK));

endmodule

// File: tb/sim_lpa_arbiter.sv
module sim_lpa_arbiter;

    localparam int NS = 4;
    localparam int CB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src, tedge, tinv, swset, clr, ie, vec;
    logic [NS*8-1:0] ctl;
    logic [3:0]    nlb;
    logic [7:0]    thr;
    logic [NS-1:0] pend;
    logic          irq;
    logic [1:0]    wid;
    logic [7:0]    wlvl;
    logic          wvec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lpa_arbiter #(.N(NS), .CTL_BITS(CB)) u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .trig_edge_i(tedge),
        .trig_inv_i(tinv), .sw_set_i(swset), .clr_i(clr), .ie_i(ie),
        .ctl_i(ctl), .vec_i(vec), .nlbits_i(nlb), .thresh_i(thr),
        .pend_o(pend), .irq_o(irq), .win_id_o(wid), .win_lvl_o(wlvl),
        .win_vec_o(wvec)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet();
        src = '0; tedge = '0; tinv = '0; swset = '0; clr = '0;
        ie = '0; vec = '0; ctl = '0; nlb = '0; thr = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    function automatic int eff(int c);
        return (c & 'hF0) | 'h0F;
    endfunction

    function automatic int nlc(int n);
        return (n > CB) ? CB : n;
    endfunction

    function automatic int lvl_of(int c, int n);
        return eff(c) | (255 >> nlc(n));
    endfunction

    function automatic int prio_of(int c, int n);
        return eff(c) & (255 >> nlc(n));
    endfunction

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        quiet();
        step(2);
        // R1: reset values
        chk("R1 pend", int'(pend), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 id", int'(wid), 0);
        chk("R1 lvl", int'(wlvl), 0);
        chk("R1 vec", int'(wvec), 0);
        rst_n = 1'b1;
        step(1);

        // R2 R3: full control byte sweep over every level-bit count
        src[2] = 1'b1; ie[2] = 1'b1;
        step(2);
        for (int n = 0; n <= 8; n++) begin
            for (int c = 0; c < 256; c++) begin
                nlb = 4'(n);
                ctl[23:16] = 8'(c);
                step(1);
                chk("R2 R3 level", int'(wlvl), lvl_of(c, n));
                chk("R3 id", int'(wid), 2);
            end
        end

        // R6: threshold sweep, level 127
        nlb = 4'd2; ctl[23:16] = 8'h40;
        for (int t = 0; t < 256; t++) begin
            thr = 8'(t);
            step(1);
            chk("R6 irq", int'(irq), (127 > t) ? 1 : 0);
        end
        nlb = 4'd0; thr = 8'd255;
        step(1);
        chk("R6 level255 thr255", int'(irq), 0);
        chk("R6 level255", int'(wlvl), 255);

        // R4 R5 R12: random arbitration over four level-captured lines
        quiet();
        src = 4'hF;
        step(2);
        seed = 32'h1234_5678;
        for (int t = 0; t < 400; t++) begin
            int c [NS];
            int n;
            int bl, bp, bi;
            bit fnd;
            seed = seed * 1103515245 + 12345;
            ie = 4'(seed >> 16);
            vec = 4'(seed >> 20);
            n = int'((seed >> 24) % 9);
            nlb = 4'(n);
            for (int i = 0; i < NS; i++) begin
                seed = seed * 1103515245 + 12345;
                c[i] = int'((seed >> 16) & 8'hFF);
                if (t % 5 == 0) c[i] = c[i] & 'hC0; // force ties
                ctl[i*8 +: 8] = 8'(c[i]);
            end
            fnd = 1'b0; bl = 0; bp = 0; bi = 0;
            for (int i = 0; i < NS; i++) begin
                if (ie[i]) begin
                    int lv, pr;
                    lv = lvl_of(c[i], n);
                    pr = prio_of(c[i], n);
                    if (!fnd || lv > bl || (lv == bl && pr >= bp)) begin
                        fnd = 1'b1; bl = lv; bp = pr; bi = i;
                    end
                end
            end
            step(1);
            if (fnd) begin
                chk("R5 id", int'(wid), bi);
                chk("R5 lvl", int'(wlvl), bl);
                chk("R12 vec", int'(wvec), int'(vec[bi]));
                chk("R6 irq", int'(irq), 1);
            end else begin
                chk("R4 id", int'(wid), 0);
                chk("R4 lvl", int'(wlvl), 0);
                chk("R4 vec", int'(wvec), 0);
                chk("R4 irq", int'(irq), 0);
            end
        end

        // R11: latency from a line change
        quiet();
        do_reset();
        ie[1] = 1'b1; ctl[15:8] = 8'hA0; nlb = 4'd2;
        step(2);
        src[1] = 1'b1;
        step(1);
        chk("R9 pend after one cycle", int'(pend[1]), 1);
        chk("R11 irq not yet", int'(irq), 0);
        step(1);
        chk("R11 irq", int'(irq), 1);
        chk("R11 id", int'(wid), 1);

        // R9: level capture ignores clear, follows line
        clr[1] = 1'b1;
        step(1);
        chk("R9 clear ignored", int'(pend[1]), 1);
        clr[1] = 1'b0; src[1] = 1'b0;
        step(1);
        chk("R9 pend drops", int'(pend[1]), 0);
        step(1);
        chk("R9 irq drops", int'(irq), 0);

        // R8: active-low level
        tinv[1] = 1'b1;
        step(1);
        chk("R8 active low set", int'(pend[1]), 1);
        src[1] = 1'b1;
        step(1);
        chk("R8 active low clear", int'(pend[1]), 0);

        // R7: rising edge capture
        tinv[1] = 1'b0; src[1] = 1'b0; tedge[1] = 1'b1;
        step(2);
        chk("R7 idle", int'(pend[1]), 0);
        src[1] = 1'b1;
        step(1);
        chk("R7 edge sets", int'(pend[1]), 1);
        src[1] = 1'b0;
        step(3);
        chk("R7 holds", int'(pend[1]), 1);
        chk("R7 irq held", int'(irq), 1);
        clr[1] = 1'b1;
        step(1);
        clr[1] = 1'b0;
        chk("R7 clear", int'(pend[1]), 0);
        src[1] = 1'b1;
        step(1);
        chk("R7 second edge", int'(pend[1]), 1);
        clr[1] = 1'b1;
        step(1);
        clr[1] = 1'b0;
        step(2);
        chk("R7 held line no reset", int'(pend[1]), 0);
        src[1] = 1'b0;
        step(1);
        src[1] = 1'b1; clr[1] = 1'b1;
        step(1);
        clr[1] = 1'b0;
        chk("R7 set beats clear", int'(pend[1]), 1);

        // R8: falling edge capture
        tinv[1] = 1'b1;
        clr[1] = 1'b1;
        step(1);
        clr[1] = 1'b0;
        chk("R8 cleared", int'(pend[1]), 0);
        src[1] = 1'b0;
        step(1);
        chk("R8 falling sets", int'(pend[1]), 1);
        clr[1] = 1'b1;
        step(1);
        clr[1] = 1'b0;
        src[1] = 1'b1;
        step(2);
        chk("R8 rising ignored", int'(pend[1]), 0);

        // R10: software set in both modes
        quiet();
        do_reset();
        swset[3] = 1'b1;
        step(1);
        swset[3] = 1'b0;
        chk("R10 level sw set", int'(pend[3]), 1);
        step(1);
        chk("R10 level sw one cycle", int'(pend[3]), 0);
        tedge[0] = 1'b1;
        step(1);
        swset[0] = 1'b1;
        step(1);
        swset[0] = 1'b0;
        chk("R10 edge sw set", int'(pend[0]), 1);
        step(2);
        chk("R10 edge sw holds", int'(pend[0]), 1);
        chk("R4 not enabled", int'(irq), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule